// File: doc/BRIEF.md
# Asynchronous Bus Cycle Slave

This block is the slave side of an asynchronous expansion bus. The master opens each cycle with an address phase, marked by an active-low address strobe. It follows with a command phase, opened by the falling edge of an active-low command strobe. The cycle closes with a data phase, which the slave may stretch. Every bus input is sampled on the internal clock. A strobe "edge" is the first internal clock edge at which the strobe is seen low after being seen high.

The internal target is a pair of small word stores, one for memory space and one for I/O space. Each store is written and read through byte lanes, which gives 8-, 16- and 32-bit transfers. While the target is busy, the block holds its ready output low, and the number of wait cycles depends on the address space. It checks even parity on the address and on the enabled write lanes. A parity fault gives a one-clock low pulse on the channel-check output and sets a sticky error flag. Read data carries a parity bit for each lane.

Top module: `bus_slave_ctrl`

## Requirements
- R1: After reset, rdy is 1, chk_n is 1, rdata is 0 and err_flag is 0, and both stores hold zero.
- R2: addr, apar and mem_io are captured at the clock where the falling edge of ads_n is seen. Later changes to these inputs during the cycle have no effect.
- R3: st_n is decoded at the command edge: st_n=2'b10 is a write and st_n=2'b01 is a read. The codes 2'b00 and 2'b11 start no transfer, leave rdy at 1 and leave both stores unchanged.
- R4: For a read or write, rdy goes low from the clock after the command edge. It stays low for MEM_WAIT clocks (mem_io=1) or IO_WAIT clocks (mem_io=0), then returns to 1.
- R5: Memory space uses word index addr[5:2] and I/O space uses addr[3:2]. The two stores are distinct, so a write to one leaves the other unchanged.
- R6: be_n[i]=0 enables lane i (bits 8i+7:8i). A write changes only the enabled lanes. Read data on the disabled lanes is zero.
- R7: Read data appears together with rdy returning to 1 and holds while cmd_n stays low. rdata returns to 0 on the clock after cmd_n is seen high.
- R8: A command strobe held low for any number of extra clocks leaves rdy and rdata stable until it is released.
- R9: The address parity is even: an error is flagged when the XOR of addr and apar is 1. A cycle with an address error writes nothing and reads zero, and chk_n pulses low in the clock after the address capture.
- R10: dpar[i] gives even parity for lane i, and is checked only on writes and only for enabled lanes. Any error suppresses the whole write, and chk_n pulses low in the clock after the command edge.
- R11: Each chk_n pulse lasts exactly one clock.
- R12: err_flag is set together with every chk_n pulse and stays set until err_clr is sampled high. If a set and a clear fall on the same clock, the set wins.
- R13: rpar[i] is the XOR of lane i of rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ads_n | input | 1 | Address strobe, active low |
| cmd_n | input | 1 | Command strobe, active low |
| st_n | input | 2 | Cycle-type status lines, active low |
| mem_io | input | 1 | 1 selects memory space, 0 selects I/O space |
| addr | input | AW | Address |
| apar | input | 1 | Even parity over addr |
| be_n | input | NB | Byte-lane enables, active low |
| wdata | input | DW | Write data |
| dpar | input | NB | Even parity for each write lane |
| err_clr | input | 1 | Clears the sticky error flag |
| rdata | output | DW | Read data |
| rpar | output | NB | Even parity for each read lane |
| rdy | output | 1 | Channel ready, low while the cycle is stretched |
| chk_n | output | 1 | Channel-check pulse, active low |
| err_flag | output | 1 | Sticky parity-error flag |

## Verification
Let P0 be the clock that captures the address and P1 the clock that sees the command edge. An address fault shows on chk_n one clock after P0, and a write-lane fault one clock after P1. rdy falls one clock after P1 and rises, with read data, MEM_WAIT or IO_WAIT clocks after P1. rdata clears one clock after the release of cmd_n is sampled. The reference model updates its expected values 1 ns after the clock edge at which each change is due. Every output is compared 2 ns after each rising edge, so each comparison reads settled registers for that exact cycle.

// File: rtl/bus_slave_pkg.sv
package bus_slave_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WAIT,
        PH_DONE
    } phase_e;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_READ,
        KIND_WRITE
    } kind_e;

    function automatic kind_e decode_kind(input logic [1:0] st_n);
        case (st_n)
            2'b10:   return KIND_WRITE;
            2'b01:   return KIND_READ;
            default: return KIND_NONE;
        endcase
    endfunction

endpackage

// File: rtl/bus_parity_chk.sv
module bus_parity_chk #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int NB = DW / 8
) (
    input  logic [AW-1:0] addr,
    input  logic          apar,
    input  logic [DW-1:0] wdata,
    input  logic [NB-1:0] dpar,
    input  logic [NB-1:0] be_n,
    input  logic [DW-1:0] rdata,
    output logic          addr_err,
    output logic          data_err,
    output logic [NB-1:0] rpar
);

    logic [NB-1:0] lane_bad;

    assign addr_err = ^{addr, apar};

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign lane_bad[i] = (^{wdata[8*i +: 8], dpar[i]}) & ~be_n[i];
        assign rpar[i]     = ^rdata[8*i +: 8];
    end

    assign data_err = |lane_bad;

endmodule

// File: rtl/bus_slave_store.sv
module bus_slave_store #(
    parameter int DW        = 32,
    parameter int NB        = DW / 8,
    parameter int MEM_WORDS = 16,
    parameter int IO_WORDS  = 4,
    localparam int MIW      = $clog2(MEM_WORDS),
    localparam int IIW      = $clog2(IO_WORDS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic           mem_sel,
    input  logic [MIW-1:0] mem_idx,
    input  logic [IIW-1:0] io_idx,
    input  logic [NB-1:0]  wbe,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rd_data
);

    logic [DW-1:0] mem_q [MEM_WORDS];
    logic [DW-1:0] io_q  [IO_WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < MEM_WORDS; w++) mem_q[w] <= '0;
            for (int w = 0; w < IO_WORDS; w++)  io_q[w]  <= '0;
        end else if (we) begin
            for (int b = 0; b < NB; b++) begin
                if (wbe[b]) begin
                    if (mem_sel) mem_q[mem_idx][8*b +: 8] <= wdata[8*b +: 8];
                    else         io_q[io_idx][8*b +: 8]   <= wdata[8*b +: 8];
                end
            end
        end
    end

    assign rd_data = mem_sel ? mem_q[mem_idx] : io_q[io_idx];

endmodule

// File: rtl/bus_slave_ctrl.sv
module bus_slave_ctrl
    import bus_slave_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int NB        = DW / 8,
    parameter int MEM_WORDS = 16,
    parameter int IO_WORDS  = 4,
    parameter int MEM_WAIT  = 3,
    parameter int IO_WAIT   = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ads_n,
    input  logic          cmd_n,
    input  logic [1:0]    st_n,
    input  logic          mem_io,
    input  logic [AW-1:0] addr,
    input  logic          apar,
    input  logic [NB-1:0] be_n,
    input  logic [DW-1:0] wdata,
    input  logic [NB-1:0] dpar,
    input  logic          err_clr,
    output logic [DW-1:0] rdata,
    output logic [NB-1:0] rpar,
    output logic          rdy,
    output logic          chk_n,
    output logic          err_flag
);

    localparam int MIW  = $clog2(MEM_WORDS);
    localparam int IIW  = $clog2(IO_WORDS);
    localparam int MAXW = (MEM_WAIT > IO_WAIT) ? MEM_WAIT : IO_WAIT;
    localparam int CW   = $clog2(MAXW + 1);

    typedef struct packed {
        phase_e         phase;
        logic [CW-1:0]  cnt;
        logic           rdy;
        logic           chk_n;
        logic           err;
        logic           ads_prev;
        logic           cmd_prev;
        logic [MIW-1:0] midx;
        logic [IIW-1:0] iidx;
        logic           mem;
        logic           addr_bad;
        logic           drop;
        logic           is_wr;
        logic [NB-1:0]  be;
        logic [DW-1:0]  wdata;
        logic [DW-1:0]  rdata;
    } regs_t;

    regs_t r_q, r_d;

    logic          addr_err, data_err;
    logic          store_we;
    logic [DW-1:0] store_rd;
    logic [DW-1:0] lane_mask;
    kind_e         kind;

    bus_parity_chk #(.AW(AW), .DW(DW), .NB(NB)) i_par (
        .addr     (addr),
        .apar     (apar),
        .wdata    (wdata),
        .dpar     (dpar),
        .be_n     (be_n),
        .rdata    (r_q.rdata),
        .addr_err (addr_err),
        .data_err (data_err),
        .rpar     (rpar)
    );

    bus_slave_store #(.DW(DW), .NB(NB), .MEM_WORDS(MEM_WORDS), .IO_WORDS(IO_WORDS)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (store_we),
        .mem_sel (r_q.mem),
        .mem_idx (r_q.midx),
        .io_idx  (r_q.iidx),
        .wbe     (r_q.be),
        .wdata   (r_q.wdata),
        .rd_data (store_rd)
    );

    always_comb begin
        for (int b = 0; b < NB; b++) lane_mask[8*b +: 8] = {8{r_q.be[b]}};
    end

    always_comb begin
        r_d          = r_q;
        r_d.ads_prev = ads_n;
        r_d.cmd_prev = cmd_n;
        r_d.chk_n    = 1'b1;
        store_we     = 1'b0;
        kind         = decode_kind(st_n);

        // clear first so that a same-cycle set wins
        if (err_clr) r_d.err = 1'b0;

        // address phase
        if (!ads_n && r_q.ads_prev) begin
            r_d.midx     = addr[2 +: MIW];
            r_d.iidx     = addr[2 +: IIW];
            r_d.mem      = mem_io;
            r_d.addr_bad = addr_err;
            if (addr_err) begin
                r_d.chk_n = 1'b0;
                r_d.err   = 1'b1;
            end
        end

        case (r_q.phase)
            PH_IDLE: begin
                if (!cmd_n && r_q.cmd_prev && kind != KIND_NONE) begin
                    r_d.is_wr = (kind == KIND_WRITE);
                    r_d.be    = ~be_n;
                    r_d.wdata = wdata;
                    r_d.cnt   = r_q.mem ? CW'(MEM_WAIT) : CW'(IO_WAIT);
                    r_d.rdy   = 1'b0;
                    r_d.phase = PH_WAIT;
                    r_d.drop  = r_q.addr_bad;
                    if (kind == KIND_WRITE && data_err) begin
                        r_d.drop  = 1'b1;
                        r_d.chk_n = 1'b0;
                        r_d.err   = 1'b1;
                    end
                end
            end
            PH_WAIT: begin
                if (r_q.cnt == CW'(1)) begin
                    r_d.phase = PH_DONE;
                    r_d.rdy   = 1'b1;
                    if (!r_q.drop) begin
                        if (r_q.is_wr) store_we  = 1'b1;
                        else           r_d.rdata = store_rd & lane_mask;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            PH_DONE: begin
                if (cmd_n) begin
                    r_d.phase = PH_IDLE;
                    r_d.rdata = '0;
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.phase    <= PH_IDLE;
            r_q.rdy      <= 1'b1;
            r_q.chk_n    <= 1'b1;
            r_q.ads_prev <= 1'b1;
            r_q.cmd_prev <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata    = r_q.rdata;
    assign rdy      = r_q.rdy;
    assign chk_n    = r_q.chk_n;
    assign err_flag = r_q.err;

endmodule

// File: rtl/bus_slave_ctrl_chk.sv
module bus_slave_ctrl_chk #(
    parameter int DW = 32,
    parameter int NB = DW / 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_n,
    input logic [1:0]    st_n,
    input logic [NB-1:0] be_n,
    input logic [DW-1:0] rdata,
    input logic          rdy,
    input logic          chk_n,
    input logic          err_flag,
    input logic          err_clr
);

    logic [DW-1:0] off_lanes;

    always_comb begin
        for (int b = 0; b < NB; b++) off_lanes[8*b +: 8] = {8{be_n[b]}};
    end

    a_r4_wait_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cmd_n) && (st_n == 2'b10 || st_n == 2'b01)) |=> !rdy);

    a_r11_chk_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_n |=> chk_n);

    a_r12_err_with_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_n |-> err_flag);

    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n && $past(cmd_n)) |-> (rdata == '0));

    a_r6_off_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_n && !$past(cmd_n)) |-> ((rdata & off_lanes) == '0));

endmodule

bind bus_slave_ctrl bus_slave_ctrl_chk #(.DW(DW), .NB(NB)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_n    (cmd_n),
    .st_n     (st_n),
    .be_n     (be_n),
    .rdata    (rdata),
    .rdy      (rdy),
    .chk_n    (chk_n),
    .err_flag (err_flag),
    .err_clr  (err_clr)
);

// File: tb/test_bus_slave_ctrl.sv
module test_bus_slave_ctrl;

    localparam logic [1:0] ST_WR = 2'b10;
    localparam logic [1:0] ST_RD = 2'b01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ads_n = 1'b1, cmd_n = 1'b1, mem_io = 1'b0, apar = 1'b0, err_clr = 1'b0;
    logic [1:0]  st_n = 2'b11;
    logic [15:0] addr = '0;
    logic [3:0]  be_n = 4'hF, dpar = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  rpar;
    logic        rdy, chk_n, err_flag;

    always #4 clk = ~clk;

    bus_slave_ctrl i_bus_slave_ctrl (
        .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .cmd_n(cmd_n), .st_n(st_n),
        .mem_io(mem_io), .addr(addr), .apar(apar), .be_n(be_n), .wdata(wdata),
        .dpar(dpar), .err_clr(err_clr), .rdata(rdata), .rpar(rpar), .rdy(rdy),
        .chk_n(chk_n), .err_flag(err_flag)
    );

    // behavioural reference state
    logic [31:0] m_mem [16];
    logic [31:0] m_io  [4];
    logic        exp_rdy = 1'b1, exp_chk = 1'b1, exp_err = 1'b0;
    logic [31:0] exp_rdata = '0;
    string       cur_req = "R1";
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    function automatic logic [3:0] lane_par(input logic [31:0] v);
        for (int i = 0; i < 4; i++) lane_par[i] = ^v[8*i +: 8];
    endfunction

    function automatic logic [31:0] lane_mask(input logic [3:0] ben);
        for (int i = 0; i < 4; i++) lane_mask[8*i +: 8] = ben[i] ? 8'h00 : 8'hFF;
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // compare every clock, 2 ns after the rising edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            check("rdy", {31'd0, rdy}, {31'd0, exp_rdy});
            check("chk_n", {31'd0, chk_n}, {31'd0, exp_chk});
            check("err_flag", {31'd0, err_flag}, {31'd0, exp_err});
            check("rdata", rdata, exp_rdata);
            check("rpar", {28'd0, rpar}, {28'd0, lane_par(exp_rdata)});
        end
    end

    task automatic bus_cycle(input logic [1:0] stv, input bit mem, input logic [15:0] a,
                             input logic [3:0] ben, input logic [31:0] d, input bit bad_a,
                             input logic [3:0] bad_l, input int hold, input bit clr);
        bit valid, wr, lane_err, drop;
        int lat;
        valid    = (stv == ST_RD) || (stv == ST_WR);
        wr       = (stv == ST_WR);
        lane_err = wr && ((bad_l & ~ben) != 4'h0);
        drop     = bad_a || lane_err;
        lat      = mem ? 3 : 1;
        @(negedge clk);
        ads_n = 1'b0; addr = a; mem_io = mem; apar = (^a) ^ bad_a; err_clr = clr;
        @(posedge clk); #1;
        if (bad_a) begin exp_chk = 1'b0; exp_err = 1'b1; end   // R9, R12 (set wins)
        else if (clr) exp_err = 1'b0;
        @(negedge clk);
        // R2: address inputs change after capture
        ads_n = 1'b1; err_clr = 1'b0; addr = ~a; mem_io = ~mem; apar = 1'b0;
        cmd_n = 1'b0; st_n = stv; be_n = ben; wdata = d; dpar = lane_par(d) ^ bad_l;
        @(posedge clk); #1;
        exp_chk = 1'b1;                                         // R11
        if (valid) exp_rdy = 1'b0;                              // R4
        if (lane_err) begin exp_chk = 1'b0; exp_err = 1'b1; end // R10
        if (valid) begin
            for (int i = 1; i <= lat; i++) begin
                @(posedge clk); #1;
                if (i == 1) exp_chk = 1'b1;
                if (i == lat) begin
                    exp_rdy = 1'b1;
                    if (!drop) begin
                        if (wr) begin
                            for (int b = 0; b < 4; b++) if (!ben[b]) begin
                                if (mem) m_mem[a[5:2]][8*b +: 8] = d[8*b +: 8];
                                else     m_io[a[3:2]][8*b +: 8]  = d[8*b +: 8];
                            end
                        end else begin
                            exp_rdata = (mem ? m_mem[a[5:2]] : m_io[a[3:2]]) & lane_mask(ben);
                        end
                    end
                end
            end
        end
        repeat (hold) @(negedge clk);                            // R8
        @(negedge clk);
        cmd_n = 1'b1; st_n = 2'b11; be_n = 4'hF;
        @(posedge clk); #1;
        exp_rdata = '0;                                          // R7
        exp_chk = 1'b1;
    endtask

    task automatic clear_err();
        @(negedge clk); err_clr = 1'b1;
        @(posedge clk); #1; exp_err = 1'b0;
        @(negedge clk); err_clr = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        for (int i = 0; i < 4; i++)  m_io[i]  = '0;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check("reset rdy", {31'd0, rdy}, 32'd1);
        check("reset chk_n", {31'd0, chk_n}, 32'd1);
        check("reset rdata", rdata, 32'd0);
        rst_n = 1'b1;
        bus_cycle(ST_RD, 1'b1, 16'h0010, 4'h0, '0, 0, 4'h0, 0, 0);   // R1 store empty

        cur_req = "R4";
        bus_cycle(ST_WR, 1'b1, 16'h0010, 4'h0, 32'hA5C3_1E77, 0, 4'h0, 0, 0);
        bus_cycle(ST_RD, 1'b1, 16'h0010, 4'h0, '0, 0, 4'h0, 0, 0);
        cur_req = "R5";
        bus_cycle(ST_WR, 1'b0, 16'h0010, 4'h0, 32'h0BAD_F00D, 0, 4'h0, 0, 0);
        bus_cycle(ST_RD, 1'b1, 16'h0010, 4'h0, '0, 0, 4'h0, 0, 0);
        bus_cycle(ST_RD, 1'b0, 16'h0010, 4'h0, '0, 0, 4'h0, 0, 0);
        bus_cycle(ST_RD, 1'b0, 16'h0004, 4'h0, '0, 0, 4'h0, 0, 0);

        cur_req = "R6";
        bus_cycle(ST_WR, 1'b1, 16'h0010, 4'hE, 32'hFFFF_FF42, 0, 4'h0, 0, 0);
        bus_cycle(ST_WR, 1'b1, 16'h0010, 4'h3, 32'h9911_FFFF, 0, 4'h0, 0, 0);
        bus_cycle(ST_RD, 1'b1, 16'h0010, 4'h0, '0, 0, 4'h0, 0, 0);
        bus_cycle(ST_RD, 1'b1, 16'h0010, 4'hC, '0, 0, 4'h0, 0, 0);
        bus_cycle(ST_RD, 1'b1, 16'h0010, 4'h7, '0, 0, 4'h0, 0, 0);

        cur_req = "R3";
        bus_cycle(2'b11, 1'b1, 16'h0010, 4'h0, 32'h1234_5678, 0, 4'h0, 0, 0);
        bus_cycle(2'b00, 1'b1, 16'h0010, 4'h0, 32'h1234_5678, 0, 4'h0, 0, 0);
        bus_cycle(ST_RD, 1'b1, 16'h0010, 4'h0, '0, 0, 4'h0, 0, 0);

        cur_req = "R8";
        bus_cycle(ST_WR, 1'b1, 16'h003C, 4'h0, 32'h5555_AAAA, 0, 4'h0, 6, 0);
        bus_cycle(ST_RD, 1'b1, 16'h003C, 4'h0, '0, 0, 4'h0, 9, 0);
        cur_req = "R7";
        bus_cycle(ST_RD, 1'b0, 16'h000C, 4'h0, '0, 0, 4'h0, 2, 0);

        cur_req = "R9";
        bus_cycle(ST_WR, 1'b1, 16'h003C, 4'h0, 32'hDEAD_0001, 1, 4'h0, 0, 0);
        bus_cycle(ST_RD, 1'b1, 16'h003C, 4'h0, '0, 1, 4'h0, 0, 0);
        cur_req = "R12";
        bus_cycle(ST_RD, 1'b1, 16'h003C, 4'h0, '0, 0, 4'h0, 0, 0);
        clear_err();
        cur_req = "R10";
        bus_cycle(ST_WR, 1'b1, 16'h003C, 4'h0, 32'hCAFE_0002, 0, 4'h4, 0, 0);
        bus_cycle(ST_RD, 1'b1, 16'h003C, 4'h0, '0, 0, 4'h0, 0, 0);
        bus_cycle(ST_WR, 1'b1, 16'h003C, 4'hB, 32'hCAFE_7702, 0, 4'h4, 0, 0);
        bus_cycle(ST_RD, 1'b1, 16'h003C, 4'h0, '0, 0, 4'h0, 0, 0);
        bus_cycle(ST_RD, 1'b1, 16'h003C, 4'h0, '0, 0, 4'h2, 0, 0);
        cur_req = "R12";
        bus_cycle(ST_RD, 1'b0, 16'h0008, 4'h0, '0, 1, 4'h0, 0, 1);
        clear_err();
        cur_req = "R13";
        bus_cycle(ST_WR, 1'b0, 16'h0008, 4'h0, 32'h0103_0701, 0, 4'h0, 0, 0);
        bus_cycle(ST_RD, 1'b0, 16'h0008, 4'h0, '0, 0, 4'h0, 0, 0);
        cur_req = "R2";
        bus_cycle(ST_RD, 1'b1, 16'h0010, 4'h0, '0, 0, 4'h0, 0, 0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule